// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of interrupt request lines, filters them through a mask register, and assigns each surviving request to one of seven interrupt levels. It drives a 7-bit decoded level bus toward the processor core. Each bit of that bus shows that at least one live request sits at that level.

When the core acknowledges an interrupt, it issues a byte read whose address carries the level being served. The block then arbitrates among the live requests at that level and returns an 8-bit vector that identifies the winning source. If nothing is pending at that level, it returns a spurious vector instead.

Sources 1 to 7 are hardwired. Each one sits at its own level, with a rank halfway through the programmable priority range. Every higher-numbered source has a control byte that software writes to set its level and its rank within that level. The mask register and the control bytes share one byte-wide register port.

Top module: `pic_top`

## Requirements
- R1: A source is live only while its request line is high, its mask bit is 0 and its effective level is nonzero. Source 0 is never live. With every mask bit set, the level bus is all zero.
- R2: Level bus bit n (n = 1..7) is high exactly when at least one live source has effective level n.
- R3: Source n (n = 1..7) always has level n. Its rank lies above programmable priority 3 and below programmable priority 4. Its control address reads 0x00, and writes to that address are ignored.
- R4: A programmable source k (k >= 8) has its control byte at register address k. Bits 5:3 hold the level and bits 2:0 hold the priority. Bits 7:6 are discarded and read as 0. Address 0 reads 0x00.
- R5: Within one level, programmable priority 7 wins over every lower priority, and priority 0 loses to all others.
- R6: When two live sources at the acknowledged level have the same rank, the lower source number wins.
- R7: During an acknowledge read, the level comes from address bits 4:2, and the other address bits are ignored. The returned vector is 64 plus the number of the winning source.
- R8: When no live source exists at the acknowledged level, the returned vector is 24. This includes every acknowledge of level 0.
- R9: The acknowledge data is registered. The ready output is high for exactly one clock, starting one clock after the read strobe, and low at all other times.
- R10: After reset, every control byte reads 0x00 and every mask bit is 1.
- R11: Mask byte j is at register address 0x80 + j, and its bit b controls source 8j + b. A mask bit of 1 blocks that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Request line per source; bit i belongs to source i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (control bytes, then mask bytes at 0x80) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| level_req | output | 7 | Decoded level bus, bits 7:1 |
| iack_rd | input | 1 | Acknowledge read strobe |
| iack_addr | input | 5 | Acknowledge address; bits 4:2 carry the level |
| iack_vec | output | 8 | Returned vector |
| iack_ready | output | 1 | One-clock pulse marking a valid vector |

## Verification
Some properties are checked by assertions on every cycle. These cover:
- the timing of the ready pulse one clock after the strobe;
- the rule that a returned vector is either 24 or above 64;
- the rule that a fully set mask silences the level bus;
- the rule that an acknowledge with an empty level bus yields the spurious vector;
- the mask being all ones on leaving reset.

Other behaviour can only be shown by the bench scenarios. This covers:
- which source actually wins (the midpoint placement of the fixed sources, priority ordering, and tie-breaking on source number);
- the register field layout;
- the fact that writes to the fixed sources are ignored.

The bench shows these by sweeping request patterns against a model that it computes itself.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int          VEC_BASE     = 64;
    localparam logic [7:0]  SPURIOUS_VEC = 8'd24;
    localparam int          FIXED_LAST   = 7;
    localparam logic [7:0]  MASK_BASE    = 8'h80;

    // Per-source configuration: level then priority.
    typedef struct packed {
        logic [2:0] level;
        logic [2:0] prio;
    } src_cfg_t;

    // Rank scale 0..8: programmable 0..3 -> 0..3, 4..7 -> 5..8, fixed -> 4.
    typedef logic [3:0] rank_t;

    localparam rank_t MID_RANK = 4'd4;

    function automatic rank_t prog_rank(input logic [2:0] p);
        return p[2] ? ({1'b0, p} + 4'd1) : {1'b0, p};
    endfunction

    typedef struct packed {
        logic       hit;
        logic [7:0] src;
        rank_t      rank;
    } pick_t;

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [7:0]                   addr,
    input  logic [7:0]                   wdata,
    output logic [7:0]                   rdata,
    output src_cfg_t [NUM_SRC-1:0]       cfg,
    output logic [NUM_SRC-1:0]           mask
);

    localparam int MASK_BYTES = NUM_SRC / 8;

    logic [1:0] unused_wdata_hi;
    assign unused_wdata_hi = wdata[7:6];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i == 0) begin : g_none
            assign cfg[i] = '0;
        end else if (i <= FIXED_LAST) begin : g_fixed
            assign cfg[i] = '{level: 3'(i), prio: 3'd0};
        end else begin : g_prog
            src_cfg_t cfg_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cfg_q <= '0;
                else if (we && addr == 8'(i))
                    cfg_q <= wdata[5:0];
            end
            assign cfg[i] = cfg_q;
        end
    end

    for (genvar j = 0; j < MASK_BYTES; j++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask[8*j +: 8] <= 8'hFF;
            else if (we && addr == MASK_BASE + 8'(j))
                mask[8*j +: 8] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = FIXED_LAST + 1; i < NUM_SRC; i++)
            if (addr == 8'(i))
                rdata = {2'b00, cfg[i]};
        for (int j = 0; j < MASK_BYTES; j++)
            if (addr == MASK_BASE + 8'(j))
                rdata = mask[8*j +: 8];
    end

    assert_mask_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask));

endmodule

// File: rtl/pic_recog.sv
module pic_recog
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0]     src_req,
    input  logic [NUM_SRC-1:0]     mask,
    input  src_cfg_t [NUM_SRC-1:0] cfg,
    output logic [NUM_SRC-1:0]     active,
    output logic [7:1]             level_req
);

    logic [7:0] lvl_hit;
    logic       unused_lvl0;

    always_comb begin
        active = '0;
        for (int i = 1; i < NUM_SRC; i++)
            active[i] = src_req[i] && !mask[i] && (cfg[i].level != 3'd0);
    end

    always_comb begin
        lvl_hit = '0;
        for (int i = 1; i < NUM_SRC; i++)
            if (active[i])
                lvl_hit[cfg[i].level] = 1'b1;
    end

    assign level_req   = lvl_hit[7:1];
    assign unused_lvl0 = lvl_hit[0];

endmodule

// File: rtl/pic_ack.sv
module pic_ack
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   iack_rd,
    input  logic [2:0]             iack_lvl,
    input  logic [NUM_SRC-1:0]     active,
    input  src_cfg_t [NUM_SRC-1:0] cfg,
    output logic [7:0]             ack_vec,
    output logic                   ack_ready
);

    pick_t best;

    always_comb begin
        rank_t r;
        best = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            r = (i <= FIXED_LAST) ? MID_RANK : prog_rank(cfg[i].prio);
            if (active[i] && cfg[i].level == iack_lvl && (!best.hit || r > best.rank)) begin
                best.hit  = 1'b1;
                best.src  = 8'(i);
                best.rank = r;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_vec   <= '0;
            ack_ready <= 1'b0;
        end else begin
            ack_ready <= iack_rd;
            if (iack_rd)
                ack_vec <= best.hit ? (8'(VEC_BASE) + best.src) : SPURIOUS_VEC;
        end
    end

    assert_ready_follows_R9: assert property (@(posedge clk) disable iff (rst)
        iack_rd |=> ack_ready);
    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !iack_rd |=> !ack_ready);
    assert_vec_range_R7: assert property (@(posedge clk) disable iff (rst)
        ack_ready |-> (ack_vec == SPURIOUS_VEC || ack_vec > 8'(VEC_BASE)));

endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic [7:1]         level_req,
    input  logic               iack_rd,
    input  logic [4:0]         iack_addr,
    output logic [7:0]         iack_vec,
    output logic               iack_ready
);

    src_cfg_t [NUM_SRC-1:0] cfg;
    logic [NUM_SRC-1:0]     mask;
    logic [NUM_SRC-1:0]     active;
    logic [1:0]             unused_addr_lo;

    assign unused_addr_lo = iack_addr[1:0];

    pic_regs #(.NUM_SRC(NUM_SRC)) i_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .mask(mask)
    );

    pic_recog #(.NUM_SRC(NUM_SRC)) i_recog (
        .src_req(src_req), .mask(mask), .cfg(cfg),
        .active(active), .level_req(level_req)
    );

    pic_ack #(.NUM_SRC(NUM_SRC)) i_ack (
        .clk(clk), .rst(rst), .iack_rd(iack_rd), .iack_lvl(iack_addr[4:2]),
        .active(active), .cfg(cfg), .ack_vec(iack_vec), .ack_ready(iack_ready)
    );

    assert_full_mask_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> (level_req == 7'd0));
    assert_empty_ack_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (iack_rd && level_req == 7'd0) |=> (iack_vec == SPURIOUS_VEC));

endmodule

// File: tb/test_pic_top.sv
module test_pic_top;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_req = '0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic [7:1]   level_req;
    logic         iack_rd = 1'b0;
    logic [4:0]   iack_addr = '0;
    logic [7:0]   iack_vec;
    logic         iack_ready;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0]  m_ctl [N];
    logic [N-1:0] m_mask;

    always #5 clk = ~clk;

    pic_top #(.NUM_SRC(N)) i_pic_top (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lvl_of(input int i);
        return (i <= 7) ? i : int'(m_ctl[i][5:3]);
    endfunction

    function automatic bit live(input int i);
        return i >= 1 && src_req[i] && !m_mask[i] && lvl_of(i) != 0;
    endfunction

    function automatic int exp_levels();
        int r = 0;
        for (int i = 1; i < N; i++)
            if (live(i)) r |= (1 << lvl_of(i)) >> 1;
        return r;
    endfunction

    function automatic int exp_vec(input int lvl);
        int best = -1; int who = 0;
        for (int i = 1; i < N; i++) begin
            int score = (i <= 7) ? 7 : 2 * int'(m_ctl[i][2:0]);
            if (live(i) && lvl_of(i) == lvl && score > best) begin
                best = score; who = i;
            end
        end
        return (best < 0) ? 24 : 64 + who;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= 8 && a < N) m_ctl[a] = d & 8'h3F;
        if (a == 8'h80) m_mask[7:0] = d;
        if (a == 8'h81) m_mask[15:8] = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack(input int lvl, input logic [1:0] lo, input string req);
        int e = exp_vec(lvl);
        @(negedge clk);
        iack_rd = 1'b1; iack_addr = {3'(lvl), lo};
        @(negedge clk);
        iack_rd = 1'b0;
        chk({req, " vector"}, int'(iack_vec), e);
        chk("R9 ready", int'(iack_ready), 1);
    endtask

    initial begin
        #(10 * 150000);
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < N; i++) m_ctl[i] = '0;
        m_mask = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 / R1: reset state
        src_req = '1;
        rd(8'h80, d); chk("R10 mask byte0", d, 8'hFF);
        rd(8'h81, d); chk("R10 mask byte1", d, 8'hFF);
        rd(8'd9, d);  chk("R10 ctl", d, 0);
        chk("R1 fully masked levels", int'(level_req), 0);
        chk("R9 ready idle", int'(iack_ready), 0);
        src_req = '0;

        // R11: unmask all through the mask bytes; readback
        wr(8'h80, 8'h00); wr(8'h81, 8'h00);
        rd(8'h81, d); chk("R11 mask readback", d, 0);

        // R3 / R7: fixed sources alone, garbage low address bits
        for (int n = 1; n <= 7; n++) begin
            src_req = '0; src_req[n] = 1'b1;
            #1 chk("R3 fixed level", int'(level_req), 1 << (n - 1));
            ack(n, 2'b11, "R7 fixed");
            ack((n % 7) + 1, 2'b01, "R8 other level");
        end
        src_req = '0;
        ack(0, 2'b00, "R8 level0");

        // R3: fixed control writes ignored
        wr(8'd5, 8'h3F);
        rd(8'd5, d); chk("R3 fixed reads zero", d, 0);
        rd(8'd0, d); chk("R4 addr0 zero", d, 0);
        src_req[5] = 1'b1;
        #1 chk("R3 fixed still level5", int'(level_req), 1 << 4);
        src_req = '0;

        // R4 / R5 / R3: level 3 sweep with priorities 0..7 plus fixed source 3
        for (int i = 8; i < N; i++) begin
            wr(8'(i), {2'b11, 3'd3, 3'(i - 8)});
            rd(8'(i), d); chk("R4 field layout", d, {2'b00, 3'd3, 3'(i - 8)});
        end
        for (int p = 0; p < 512; p++) begin
            src_req = '0;
            src_req[3] = p[0];
            src_req[15:8] = 8'(p >> 1);
            #1 chk("R2 level bus", int'(level_req), exp_levels());
            ack(3, 2'b10, "R5 priority sweep");
        end

        // R6: equal priorities, lower number wins
        wr(8'd9, {2'b00, 3'd3, 3'd5});
        src_req = '0; src_req[9] = 1'b1; src_req[13] = 1'b1;
        ack(3, 2'b00, "R6 tie");
        chk("R6 tie winner", int'(iack_vec), 64 + 9);

        // R1: level 0 never requests
        wr(8'd10, {2'b00, 3'd0, 3'd7});
        src_req = '0; src_req[10] = 1'b1;
        #1 chk("R1 level zero silent", int'(level_req), 0);
        ack(0, 2'b00, "R8 level0 source");

        // R2 / R7 / R11: mixed levels, partial mask, all ack levels
        for (int i = 8; i < N; i++)
            wr(8'(i), {2'b00, 3'((i % 7) + 1), 3'((i * 3) % 8)});
        wr(8'h80, 8'h24); wr(8'h81, 8'h41);
        for (int p = 0; p < 256; p++) begin
            src_req = '0;
            src_req[15:8] = 8'(p);
            src_req[7:1] = 7'(p) ^ 7'(p >> 1);
            #1 chk("R2 mixed level bus", int'(level_req), exp_levels());
            for (int l = 0; l < 8; l++) ack(l, 2'(p), "R7 mixed");
        end

        // R9: single-cycle pulse
        @(negedge clk);
        chk("R9 pulse ends", int'(iack_ready), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule